// File: doc/BRIEF.md
# Port Upper-Nibble Interrupt and DMA Handshake Pins

This block sits on the four most significant pins of a quasi-bidirectional port. It holds the output latch for those four pins, and by default it drives each pin from its latch bit. A host-flag enable command turns the two lower pins of the nibble into buffer-status outputs that the host can use as interrupts. One pin then reports that the output buffer is full and the other reports that the input buffer is empty. In flag mode the latch bit of each of these pins gates its status output.

A separate DMA enable command turns the upper two pins into a request/acknowledge pair. The third pin then drives a DMA request that a latch write raises. The fourth pin is released high so that an external controller can pull it low as an acknowledge. While the acknowledge is low it selects the data buffer registers in place of the host chip select. The request drops on the trailing edge of an acknowledged host read or write, or when the DMA enable command is issued again. Host strobes and the acknowledge pass through a configurable synchronizer before edges are detected. Both enables stay set until reset.

Top module: `xpin_special_func`

## Requirements
- R1: After reset the latch nibble is 4'b1111, both modes are off, the request is low, and `pin_drive` equals the latch.
- R2: In flag mode `pin_drive[0]` equals latch bit 0 AND `obf`. A 0 in the latch bit forces the pin low.
- R3: In flag mode `pin_drive[1]` equals latch bit 1 AND NOT `ibf`.
- R4: In DMA mode a latch write with `port_wdata[2]`=1 raises the request, and the request appears on `pin_drive[2]` one cycle after the write. `pin_drive[3]` is held at 1.
- R5: A rising edge of `host_rd_n` or `host_wr_n` while `dack_pin_n` is low clears the request SYNC_STAGES+1 clock edges after the edge is sampled. The same edge with `dack_pin_n` high has no effect.
- R6: Each `cmd_en_dma` pulse clears the request on the next edge, even when a setting latch write arrives in the same cycle.
- R7: A latch write with bit 2 = 0 does not clear a pending request.
- R8: In DMA mode, while `dack_pin_n` is low, `buf_cs_n`=0 and `buf_a0`=0 regardless of `host_cs_n` and `host_a0`. In every other case both signals copy the host inputs, so `dack_pin_n` is ignored outside DMA mode.
- R9: Both modes stay set until reset. A pin whose mode is off follows its latch bit, for example pins 2 and 3 in flag-only mode and pins 0 and 1 in DMA-only mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_wr | input | 1 | Latch write strobe for the nibble |
| port_wdata | input | 4 | New latch nibble (bit 0 is the lowest pin) |
| cmd_en_flags | input | 1 | Enable host-flag mode pulse |
| cmd_en_dma | input | 1 | Enable DMA mode pulse (also clears request) |
| obf | input | 1 | Output buffer full status |
| ibf | input | 1 | Input buffer full status |
| host_cs_n | input | 1 | Host chip select, active low |
| host_a0 | input | 1 | Host command/data select |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| dack_pin_n | input | 1 | Level sensed on pin 3 (acknowledge) |
| pin_drive | output | 4 | Drive value for the four pins |
| buf_cs_n | output | 1 | Effective select for the buffer registers |
| buf_a0 | output | 1 | Effective command/data select for the buffers |

## Verification
The bench builds the block with SYNC_STAGES set to 2 and the reset latch value at all ones. With these values the request clear lands on a known edge: the request still reads high two edges after a strobe rises and reads low on the third. The all-ones reset lets the bench see that flag mode outputs status as soon as it is enabled. It also lets the bench see that enabling DMA hides a latch bit 2 that is already 1.

// File: rtl/xpin_pkg.sv
package xpin_pkg;
   localparam int unsigned NIB_W    = 4;
   localparam int unsigned OBF_IDX  = 0;
   localparam int unsigned IBF_IDX  = 1;
   localparam int unsigned DRQ_IDX  = 2;
   localparam int unsigned DACK_IDX = 3;

   typedef struct packed {
      logic flags_on;
      logic dma_on;
   } xpin_mode_t;
endpackage

// File: rtl/xpin_mode_reg.sv
module xpin_mode_reg
   import xpin_pkg::*;
#(
   parameter logic [NIB_W-1:0] RESET_LATCH = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             port_wr,
   input  logic [NIB_W-1:0] port_wdata,
   input  logic             cmd_en_flags,
   input  logic             cmd_en_dma,
   output logic [NIB_W-1:0] latch_q,
   output xpin_mode_t       mode_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= RESET_LATCH;
         mode_q  <= '0;
      end else begin
         if (port_wr) latch_q <= port_wdata;
         if (cmd_en_flags) mode_q.flags_on <= 1'b1;
         if (cmd_en_dma)   mode_q.dma_on   <= 1'b1;
      end
   end

   assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q.flags_on |=> mode_q.flags_on);
   assert_dma_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q.dma_on |=> mode_q.dma_on);
endmodule

// File: rtl/xpin_strobe_sync.sv
module xpin_strobe_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw_n,
   output logic [W-1:0] synced_n,
   output logic [W-1:0] rise
);
   logic [W-1:0] prev_n;

   generate
      if (STAGES > 4) begin : g_bad_depth
         $error("xpin_strobe_sync: STAGES must be 0 to 4");
      end
      if (STAGES == 0) begin : g_bypass
         assign synced_n = raw_n;
      end else begin : g_chain
         logic [W-1:0] st [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(STAGES); i++) st[i] <= '1;
            end else begin
               st[0] <= raw_n;
               for (int i = 1; i < int'(STAGES); i++) st[i] <= st[i-1];
            end
         end
         assign synced_n = st[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_n <= '1;
      else        prev_n <= synced_n;
   end

   assign rise = synced_n & ~prev_n;
endmodule

// File: rtl/xpin_drq_ctrl.sv
module xpin_drq_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic dma_on,
   input  logic cmd_en_dma,
   input  logic set_req,
   input  logic ack_rise,
   output logic drq_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)                 drq_q <= 1'b0;
      else if (cmd_en_dma)        drq_q <= 1'b0;
      else if (dma_on && set_req) drq_q <= 1'b1;
      else if (ack_rise)          drq_q <= 1'b0;
   end

   assert_drq_needs_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drq_q) |-> $past(set_req && dma_on));
   assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rise && !set_req) |=> !drq_q);
   assert_cmd_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_en_dma |=> !drq_q);
   assert_pending_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (drq_q && !ack_rise && !cmd_en_dma) |=> drq_q);
endmodule

// File: rtl/xpin_special_func.sv
module xpin_special_func
   import xpin_pkg::*;
#(
   parameter int unsigned      SYNC_STAGES = 2,
   parameter logic [3:0]       RESET_LATCH = 4'hF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       port_wr,
   input  logic [3:0] port_wdata,
   input  logic       cmd_en_flags,
   input  logic       cmd_en_dma,
   input  logic       obf,
   input  logic       ibf,
   input  logic       host_cs_n,
   input  logic       host_a0,
   input  logic       host_rd_n,
   input  logic       host_wr_n,
   input  logic       dack_pin_n,
   output logic [3:0] pin_drive,
   output logic       buf_cs_n,
   output logic       buf_a0
);
   localparam int unsigned SV_W = 3;
   localparam int unsigned RD_S = 0;
   localparam int unsigned WR_S = 1;
   localparam int unsigned DK_S = 2;

   logic [NIB_W-1:0] latch_q;
   xpin_mode_t       mode_q;
   logic [SV_W-1:0]  synced_n, rise;
   logic             ack_rise, drq_q, dack_live;
   logic             sig_unused;

   xpin_mode_reg #(.RESET_LATCH(RESET_LATCH)) u_mode (
      .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_wdata(port_wdata),
      .cmd_en_flags(cmd_en_flags), .cmd_en_dma(cmd_en_dma),
      .latch_q(latch_q), .mode_q(mode_q));

   xpin_strobe_sync #(.W(SV_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .raw_n({dack_pin_n, host_wr_n, host_rd_n}),
      .synced_n(synced_n), .rise(rise));

   assign ack_rise   = mode_q.dma_on && !synced_n[DK_S] && (rise[RD_S] || rise[WR_S]);
   assign sig_unused = ^{rise[DK_S], synced_n[WR_S], synced_n[RD_S]};

   xpin_drq_ctrl u_drq (
      .clk(clk), .rst_n(rst_n), .dma_on(mode_q.dma_on), .cmd_en_dma(cmd_en_dma),
      .set_req(port_wr && port_wdata[DRQ_IDX]), .ack_rise(ack_rise),
      .drq_q(drq_q));

   always_comb begin
      pin_drive = latch_q;
      if (mode_q.flags_on) begin
         pin_drive[OBF_IDX] = latch_q[OBF_IDX] & obf;
         pin_drive[IBF_IDX] = latch_q[IBF_IDX] & ~ibf;
      end
      if (mode_q.dma_on) begin
         pin_drive[DRQ_IDX]  = drq_q;
         pin_drive[DACK_IDX] = 1'b1;
      end
   end

   assign dack_live = mode_q.dma_on && !dack_pin_n;
   assign buf_cs_n  = dack_live ? 1'b0 : host_cs_n;
   assign buf_a0    = dack_live ? 1'b0 : host_a0;

   assert_dack_selects_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q.dma_on && !dack_pin_n) |-> (!buf_cs_n && !buf_a0));
   assert_dack_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q.dma_on |-> pin_drive[DACK_IDX]);
endmodule

// File: tb/xpin_special_func_test.sv
module xpin_special_func_test;
   localparam int S = 2;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, port_wr, cmd_en_flags, cmd_en_dma, obf, ibf;
   logic host_cs_n, host_a0, host_rd_n, host_wr_n, dack_pin_n;
   logic [3:0] port_wdata, pin_drive;
   logic buf_cs_n, buf_a0;
   int checks = 0, fails = 0;
   bit done = 0;

   xpin_special_func #(.SYNC_STAGES(S), .RESET_LATCH(4'hF)) uut (
      .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_wdata(port_wdata),
      .cmd_en_flags(cmd_en_flags), .cmd_en_dma(cmd_en_dma), .obf(obf), .ibf(ibf),
      .host_cs_n(host_cs_n), .host_a0(host_a0), .host_rd_n(host_rd_n),
      .host_wr_n(host_wr_n), .dack_pin_n(dack_pin_n), .pin_drive(pin_drive),
      .buf_cs_n(buf_cs_n), .buf_a0(buf_a0));

   // {flags_cmd, wdata[3:0], obf, ibf, expected pin_drive[3:0]}
   localparam logic [10:0] VEC [6] = '{
      {1'b0, 4'b0101, 1'b0, 1'b1, 4'b0101},
      {1'b0, 4'b1010, 1'b1, 1'b0, 4'b1010},
      {1'b1, 4'b0011, 1'b1, 1'b0, 4'b0011},
      {1'b1, 4'b0011, 1'b0, 1'b1, 4'b0000},
      {1'b1, 4'b0010, 1'b1, 1'b0, 4'b0010},
      {1'b1, 4'b1101, 1'b1, 1'b1, 4'b1101}};

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   task automatic wr_latch(input logic [3:0] d);
      @(negedge clk); port_wr = 1'b1; port_wdata = d;
      @(negedge clk); port_wr = 1'b0;
   endtask

   task automatic dma_cmd;
      @(negedge clk); cmd_en_dma = 1'b1;
      @(negedge clk); cmd_en_dma = 1'b0;
   endtask

   task automatic do_reset;
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // pulse a strobe with the chosen select, check the request around the clear point
   task automatic strobe(input bit use_rd, input logic exp_after, input string tag);
      @(negedge clk);
      if (use_rd) host_rd_n = 1'b0; else host_wr_n = 1'b0;
      repeat (3) @(negedge clk);
      host_rd_n = 1'b1; host_wr_n = 1'b1;
      repeat (S) @(negedge clk);
      chk({tag, " before clear"}, {7'd0, pin_drive[2]}, 8'd1);
      @(negedge clk);
      chk({tag, " after clear"}, {7'd0, pin_drive[2]}, {7'd0, exp_after});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual hung expected done");
         summary();
      end
   end

   initial begin
      rst_n = 0; port_wr = 0; port_wdata = 0; cmd_en_flags = 0; cmd_en_dma = 0;
      obf = 1; ibf = 1; host_cs_n = 1; host_a0 = 1; host_rd_n = 1; host_wr_n = 1;
      dack_pin_n = 1;
      do_reset();
      // R1 reset state
      chk("R1 reset pins", {4'd0, pin_drive}, 8'h0F);
      chk("R1 cs passthrough", {6'd0, buf_cs_n, buf_a0}, 8'h03);

      // R2 R3 R9 vector walk (flags mode sticky once entered)
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         obf = VEC[i][5]; ibf = VEC[i][4];
         port_wr = 1'b1; port_wdata = VEC[i][9:6]; cmd_en_flags = VEC[i][10];
         @(negedge clk);
         port_wr = 1'b0; cmd_en_flags = 1'b0;
         chk($sformatf("R2 R3 R9 vector %0d", i), {4'd0, pin_drive}, {4'd0, VEC[i][3:0]});
      end

      // R6 enabling DMA hides latch bit 2 = 1; pins 0,1 stay flag outputs
      dma_cmd();
      chk("R6 R4 dma enable", {4'd0, pin_drive}, 8'h09);
      wr_latch(4'b0100);
      chk("R4 request set", {4'd0, pin_drive}, 8'h0C);
      wr_latch(4'b0000);
      chk("R7 zero write keeps request", {4'd0, pin_drive}, 8'h0C);

      // R8 acknowledge overrides select
      @(negedge clk); dack_pin_n = 1'b0; host_cs_n = 1'b1; host_a0 = 1'b1;
      #1 chk("R8 dack select", {6'd0, buf_cs_n, buf_a0}, 8'h00);
      repeat (4) @(negedge clk);
      strobe(1'b1, 1'b0, "R5 read ack");

      // R5 strobe without acknowledge does nothing
      wr_latch(4'b0100);
      @(negedge clk); dack_pin_n = 1'b1; host_cs_n = 1'b0; host_a0 = 1'b1;
      #1 chk("R8 passthrough no dack", {6'd0, buf_cs_n, buf_a0}, 8'h01);
      repeat (4) @(negedge clk);
      strobe(1'b0, 1'b1, "R5 write no dack");
      @(negedge clk); dack_pin_n = 1'b0; host_cs_n = 1'b1;
      repeat (4) @(negedge clk);
      strobe(1'b0, 1'b0, "R5 write ack");

      // R6 reissued command clears, also against same-cycle set
      @(negedge clk); dack_pin_n = 1'b1;
      wr_latch(4'b0100);
      dma_cmd();
      chk("R6 reissue clears", {7'd0, pin_drive[2]}, 8'd0);
      @(negedge clk); cmd_en_dma = 1'b1; port_wr = 1'b1; port_wdata = 4'b0100;
      @(negedge clk); cmd_en_dma = 1'b0; port_wr = 1'b0;
      chk("R6 clear beats set", {7'd0, pin_drive[2]}, 8'd0);

      // R1 reset again, R8 dack ignored outside DMA mode
      do_reset();
      chk("R1 reset clears modes", {4'd0, pin_drive}, 8'h0F);
      @(negedge clk); dack_pin_n = 1'b0; host_cs_n = 1'b1; host_a0 = 1'b1;
      #1 chk("R8 dack ignored", {6'd0, buf_cs_n, buf_a0}, 8'h03);

      // R9 DMA-only: pins 0,1 follow latch
      @(negedge clk); dack_pin_n = 1'b1; obf = 1'b1; ibf = 1'b1;
      dma_cmd();
      wr_latch(4'b0000);
      chk("R9 dma only low", {4'd0, pin_drive}, 8'h08);
      wr_latch(4'b0011);
      chk("R9 dma only latch", {4'd0, pin_drive}, 8'h0B);

      done = 1;
      summary();
   end
endmodule